// File: doc/BRIEF.md
# Serial Flash Page Rewrite Sequencer

This block is the behavioural engine, inside a serial flash device model, that carries out the self-timed page rewrite command. It watches the byte stream received while chip select is low. It keeps the opcode and the address bytes that follow. When chip select is released after a complete rewrite command, it starts the operation. The operation runs in two timed phases. In the transfer phase the addressed page of the main array is copied into an internal page buffer. In the program phase the buffer is written back into that same page. The stored data is therefore unchanged, but the page counts as freshly programmed.

The ready pin and bit 7 of the status byte are low for the whole operation. While the operation runs, only status reads are served; every other command is dropped. The block also keeps a refresh age for each page. The age is the number of rewrite operations done in that page's sector since the page itself was last rewritten. A per-sector flag goes high when any page in the sector has gone more than `LIMIT` operations without a refresh. The array is a simple dual-port memory with a one-cycle read port for the rest of the model.

Top module: `page_rewrite_seq`

## Requirements
- R1: An operation starts only on a rising edge of `cs_n` that ends a transaction whose first byte is `REWR_OP` (default 0x5A) and that delivered at least `1+ADDR_BYTES` bytes. `ready_o` falls one clock after the edge at which `cs_n` is first sampled high.
- R2: The address bytes are taken most-significant byte first into an `8*ADDR_BYTES`-bit field. The page number is field bits `[DC_BITS+PAGE_W-1:DC_BITS]` (default `[13:10]`). The low `DC_BITS` bits and any bits above the page number are ignored.
- R3: The operation copies the addressed page, `PAGE_BYTES` bytes at array addresses `{page, index}`, into a buffer and then writes the buffer back to the same page. Afterwards every array byte, in every page, holds its previous value.
- R4: `ready_o` stays low for exactly `XFER_CYC + PROG_CYC` cycles per operation, and never for more than `T_MAX` cycles.
- R5: The status byte has bit 7 equal to `ready_o`, bit 0 equal to the OR of all `refresh_due` bits, and bits 6..1 zero.
- R6: In a transaction whose first byte is `STAT_OP` (default 0xD7), each later byte produces a one-cycle `sdo_valid` pulse on the next clock, with `sdo_byte` equal to the status at the capture edge. This also works while busy.
- R7: A rewrite command completed while busy is ignored. No further operation starts, either then or after the running one ends.
- R8: A rising edge of `cs_n` after fewer than `1+ADDR_BYTES` bytes, or after a first byte other than `REWR_OP`, starts nothing.
- R9: When an operation on page p of sector s ends, page p's age becomes 0. The age of every other page of sector s rises by one, saturating at `LIMIT+1`. A sector holds `2**SECT_PAGE_W` consecutive pages. `refresh_due[s]` is high, two clocks after the operation ends, exactly when some page in sector s has age greater than `LIMIT`.
- R10: `rd_data` returns the array byte at `rd_addr` one clock after `rd_addr` is applied.
- R11: After reset `ready_o` is 1, `refresh_due` is 0, `sdo_valid` is 0, and all ages are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low; a rising edge closes a transaction |
| byte_valid | input | 1 | One received command byte is present on `byte_data` |
| byte_data | input | 8 | Received command byte |
| sdo_valid | output | 1 | Status byte ready for shifting out |
| sdo_byte | output | 8 | Status byte: bit 7 ready, bit 0 refresh due |
| ready_o | output | 1 | Ready pin, low while a rewrite runs |
| refresh_due | output | 2**(PAGE_W-SECT_PAGE_W) | Per-sector refresh-overdue flags |
| rd_addr | input | PAGE_W+log2(PAGE_BYTES) | Array read address |
| rd_data | output | 8 | Array read data, one cycle latency |

## Verification
The assertions assume that `cs_n` is high throughout reset and that `byte_valid` is asserted only while `cs_n` is low. The stimulus tasks lower chip select before the first byte and raise it only between bytes. The assertions also assume the phase counts fit within `T_MAX`, and the bench's parameter set keeps that margin. A small `LIMIT` lets the bench drive sectors past the refresh limit, into saturation and back, in a few dozen operations.

// File: rtl/prs_pkg.sv
package prs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_PROG = 2'd2
  } rw_state_e;
endpackage

// File: rtl/prs_cmd_capture.sv
module prs_cmd_capture #(
  parameter int PAGE_W     = 4,
  parameter int ADDR_BYTES = 2,
  parameter int DC_BITS    = 10,
  parameter logic [7:0] REWR_OP = 8'h5A,
  parameter logic [7:0] STAT_OP = 8'hD7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              busy,
  input  logic [7:0]        status,
  output logic              start,
  output logic [PAGE_W-1:0] start_page,
  output logic              sdo_valid,
  output logic [7:0]        sdo_byte
);
  localparam int FIELD_W = 8 * ADDR_BYTES;
  localparam int CNT_W   = $clog2(ADDR_BYTES + 2) + 1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(ADDR_BYTES + 1);

  logic               cs_q;
  logic [CNT_W-1:0]   byte_cnt;
  logic [7:0]         opc_q;
  logic [FIELD_W-1:0] field_q;
  logic               cs_rise;
  logic               unused_field;

  assign cs_rise    = cs_n & ~cs_q;
  assign start      = cs_rise & ~busy & (opc_q == REWR_OP) & (byte_cnt >= CNT_FULL);
  assign start_page = field_q[DC_BITS +: PAGE_W];
  assign unused_field = ^field_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q     <= 1'b1;
      byte_cnt <= '0;
      opc_q    <= '0;
      field_q  <= '0;
    end else begin
      cs_q <= cs_n;
      if (cs_n) begin
        byte_cnt <= '0;
      end else if (byte_valid) begin
        if (byte_cnt == '0)
          opc_q <= byte_data;
        else if (byte_cnt < CNT_FULL)
          field_q <= {field_q[FIELD_W-9:0], byte_data};
        if (byte_cnt != CNT_FULL)
          byte_cnt <= byte_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sdo_valid <= 1'b0;
      sdo_byte  <= '0;
    end else begin
      sdo_valid <= ~cs_n & byte_valid & (byte_cnt != '0) & (opc_q == STAT_OP);
      sdo_byte  <= status;
    end
  end
endmodule

// File: rtl/prs_page_array.sv
module prs_page_array #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic [AW-1:0] a_addr,
  input  logic          a_we,
  input  logic [7:0]    a_wdata,
  output logic [7:0]    a_rdata,
  input  logic [AW-1:0] b_addr,
  output logic [7:0]    b_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++)
      mem[i] = 8'((i * 7 + 3) % 256);
  end

  always_ff @(posedge clk) begin
    if (a_we)
      mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/prs_age_tracker.sv
module prs_age_tracker #(
  parameter int PAGE_W      = 4,
  parameter int SECT_PAGE_W = 2,
  parameter int LIMIT       = 10000
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               done,
  input  logic [PAGE_W-1:0]                  done_page,
  output logic [(1<<(PAGE_W-SECT_PAGE_W))-1:0] due
);
  localparam int NPAGES = 1 << PAGE_W;
  localparam int NSECT  = 1 << (PAGE_W - SECT_PAGE_W);
  localparam int AGE_W  = $clog2(LIMIT + 2);
  localparam logic [AGE_W-1:0] LIM_C = AGE_W'(LIMIT);

  logic [AGE_W-1:0] age [NPAGES];
  logic [NSECT-1:0] due_d;
  logic [PAGE_W-SECT_PAGE_W-1:0] done_sect;

  assign done_sect = done_page[PAGE_W-1:SECT_PAGE_W];

  for (genvar q = 0; q < NPAGES; q++) begin : g_page
    localparam logic [PAGE_W-SECT_PAGE_W-1:0] MY_SECT = (PAGE_W-SECT_PAGE_W)'(q >> SECT_PAGE_W);
    localparam logic [PAGE_W-1:0] MY_PAGE = PAGE_W'(q);
    always_ff @(posedge clk) begin
      if (rst)
        age[q] <= '0;
      else if (done && done_sect == MY_SECT) begin
        if (done_page == MY_PAGE)
          age[q] <= '0;
        else if (age[q] <= LIM_C)
          age[q] <= age[q] + 1'b1;
      end
    end
  end

  always_comb begin
    due_d = '0;
    for (int q = 0; q < NPAGES; q++)
      if (age[q] > LIM_C)
        due_d[q >> SECT_PAGE_W] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) due <= '0;
    else     due <= due_d;
  end
endmodule

// File: rtl/page_rewrite_seq.sv
module page_rewrite_seq #(
  parameter int PAGE_W      = 4,
  parameter int PAGE_BYTES  = 8,
  parameter int SECT_PAGE_W = 2,
  parameter int ADDR_BYTES  = 2,
  parameter int DC_BITS     = 10,
  parameter int XFER_CYC    = 10,
  parameter int PROG_CYC    = 12,
  parameter int T_MAX       = 24,
  parameter int LIMIT       = 10000,
  parameter logic [7:0] REWR_OP = 8'h5A,
  parameter logic [7:0] STAT_OP = 8'hD7
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  cs_n,
  input  logic                                  byte_valid,
  input  logic [7:0]                            byte_data,
  output logic                                  sdo_valid,
  output logic [7:0]                            sdo_byte,
  output logic                                  ready_o,
  output logic [(1<<(PAGE_W-SECT_PAGE_W))-1:0]  refresh_due,
  input  logic [PAGE_W+$clog2(PAGE_BYTES)-1:0]  rd_addr,
  output logic [7:0]                            rd_data
);
  import prs_pkg::*;

  localparam int IDX_W = $clog2(PAGE_BYTES);
  localparam int ARR_W = PAGE_W + IDX_W;
  localparam int PH_W  = $clog2(XFER_CYC + PROG_CYC + PAGE_BYTES + 1);
  localparam logic [PH_W-1:0] PB_C    = PH_W'(PAGE_BYTES);
  localparam logic [PH_W-1:0] XFER_LC = PH_W'(XFER_CYC - 1);
  localparam logic [PH_W-1:0] PROG_LC = PH_W'(PROG_CYC - 1);

  rw_state_e         st;
  logic [PH_W-1:0]   ph_cnt;
  logic [PAGE_W-1:0] page_q;
  logic              rd_vld;
  logic [IDX_W-1:0]  rd_idx;
  logic [7:0]        buf_q [PAGE_BYTES];

  logic              start;
  logic [PAGE_W-1:0] start_page;
  logic              busy;
  logic              op_done;
  logic [7:0]        status;
  logic [ARR_W-1:0]  arr_addr;
  logic              arr_we;
  logic [7:0]        arr_wdata;
  logic [7:0]        arr_rdata;

  assign busy      = (st != ST_IDLE);
  assign ready_o   = ~busy;
  assign status    = {~busy, 6'b0, |refresh_due};
  assign op_done   = (st == ST_PROG) && (ph_cnt == PROG_LC);
  assign arr_addr  = {page_q, ph_cnt[IDX_W-1:0]};
  assign arr_we    = (st == ST_PROG) && (ph_cnt < PB_C);
  assign arr_wdata = buf_q[ph_cnt[IDX_W-1:0]];

  prs_cmd_capture #(
    .PAGE_W(PAGE_W), .ADDR_BYTES(ADDR_BYTES), .DC_BITS(DC_BITS),
    .REWR_OP(REWR_OP), .STAT_OP(STAT_OP)
  ) u_cmd (
    .clk(clk), .rst(rst), .cs_n(cs_n), .byte_valid(byte_valid),
    .byte_data(byte_data), .busy(busy), .status(status),
    .start(start), .start_page(start_page),
    .sdo_valid(sdo_valid), .sdo_byte(sdo_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      ph_cnt <= '0;
      page_q <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st     <= ST_XFER;
          ph_cnt <= '0;
          page_q <= start_page;
        end
        ST_XFER: begin
          ph_cnt <= ph_cnt + 1'b1;
          if (ph_cnt == XFER_LC) begin
            st     <= ST_PROG;
            ph_cnt <= '0;
          end
        end
        ST_PROG: begin
          ph_cnt <= ph_cnt + 1'b1;
          if (ph_cnt == PROG_LC) begin
            st     <= ST_IDLE;
            ph_cnt <= '0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld <= 1'b0;
      rd_idx <= '0;
    end else begin
      rd_vld <= (st == ST_XFER) && (ph_cnt < PB_C);
      rd_idx <= ph_cnt[IDX_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rd_vld)
      buf_q[rd_idx] <= arr_rdata;
  end

  prs_page_array #(.AW(ARR_W)) u_arr (
    .clk(clk), .a_addr(arr_addr), .a_we(arr_we), .a_wdata(arr_wdata),
    .a_rdata(arr_rdata), .b_addr(rd_addr), .b_rdata(rd_data)
  );

  prs_age_tracker #(
    .PAGE_W(PAGE_W), .SECT_PAGE_W(SECT_PAGE_W), .LIMIT(LIMIT)
  ) u_age (
    .clk(clk), .rst(rst), .done(op_done), .done_page(page_q), .due(refresh_due)
  );
endmodule

// File: rtl/prs_checker.sv
module prs_checker #(
  parameter int T_MAX = 24,
  parameter int NSECT = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_n,
  input logic             ready_o,
  input logic             sdo_valid,
  input logic [7:0]       sdo_byte,
  input logic [NSECT-1:0] refresh_due,
  input logic             arr_we
);
  localparam int RUN_W = $clog2(T_MAX + 2) + 1;
  localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};

  logic [RUN_W-1:0] busy_run;

  always_ff @(posedge clk) begin
    if (rst)
      busy_run <= '0;
    else if (!ready_o)
      busy_run <= (busy_run == RUN_MAX) ? busy_run : busy_run + 1'b1;
    else
      busy_run <= '0;
  end

  assert_busy_window_R4: assert property (@(posedge clk) disable iff (rst)
    busy_run <= RUN_W'(T_MAX));

  assert_start_on_cs_rise_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(ready_o) |-> ($past(cs_n) && !$past(cs_n, 2)));

  assert_status_ready_bit_R5: assert property (@(posedge clk) disable iff (rst)
    sdo_valid |-> (sdo_byte[7] == $past(ready_o)));

  assert_no_write_when_ready_R3: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> !arr_we);

  assert_due_only_after_op_R9: assert property (@(posedge clk) disable iff (rst)
    (ready_o && $past(ready_o) && $past(ready_o, 2)) |-> $stable(refresh_due));
endmodule

bind page_rewrite_seq prs_checker #(
  .T_MAX(T_MAX), .NSECT(1 << (PAGE_W - SECT_PAGE_W))
) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .ready_o(ready_o),
  .sdo_valid(sdo_valid), .sdo_byte(sdo_byte),
  .refresh_due(refresh_due), .arr_we(arr_we)
);

// File: tb/page_rewrite_seq_tb.sv
module page_rewrite_seq_tb;
  localparam int PAGE_W = 4, PAGE_BYTES = 8, SPW = 2;
  localparam int XFER = 10, PROG = 12, TMAX = 24, LIM = 3;
  localparam int NPG = 16, NARR = 128;
  localparam logic [7:0] REWR = 8'h5A, STAT = 8'hD7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic byte_valid = 1'b0;
  logic [7:0] byte_data = '0;
  logic sdo_valid;
  logic [7:0] sdo_byte;
  logic ready_o;
  logic [3:0] refresh_due;
  logic [6:0] rd_addr = '0;
  logic [7:0] rd_data;

  int tests = 0, fails = 0;
  int run = 0, last_len = 0, episodes = 0;
  int age [NPG];

  always #10 clk = ~clk;

  page_rewrite_seq #(
    .PAGE_W(PAGE_W), .PAGE_BYTES(PAGE_BYTES), .SECT_PAGE_W(SPW),
    .ADDR_BYTES(2), .DC_BITS(10), .XFER_CYC(XFER), .PROG_CYC(PROG),
    .T_MAX(TMAX), .LIMIT(LIM), .REWR_OP(REWR), .STAT_OP(STAT)
  ) u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .byte_valid(byte_valid),
    .byte_data(byte_data), .sdo_valid(sdo_valid), .sdo_byte(sdo_byte),
    .ready_o(ready_o), .refresh_due(refresh_due),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always @(negedge clk) begin
    if (rst) begin
      run = 0;
    end else if (!ready_o) begin
      run = run + 1;
    end else if (run != 0) begin
      last_len = run;
      episodes = episodes + 1;
      run = 0;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b0, input logic [7:0] b1,
                      input logic [7:0] b2, input int n);
    logic [7:0] bytes [3];
    bytes[0] = b0; bytes[1] = b1; bytes[2] = b2;
    @(negedge clk) cs_n = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk) begin byte_valid = 1'b1; byte_data = bytes[i]; end
      @(negedge clk) byte_valid = 1'b0;
    end
    @(negedge clk) cs_n = 1'b1;
  endtask

  task automatic stat_read(output logic [7:0] v, output logic vld);
    @(negedge clk) cs_n = 1'b0;
    @(negedge clk) begin byte_valid = 1'b1; byte_data = STAT; end
    @(negedge clk) byte_valid = 1'b0;
    @(negedge clk) begin byte_valid = 1'b1; byte_data = 8'h00; end
    @(negedge clk) begin vld = sdo_valid; v = sdo_byte; byte_valid = 1'b0; end
    @(negedge clk) cs_n = 1'b1;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (ready_o && run == 0) break;
    end
    repeat (3) @(negedge clk);
  endtask

  function automatic int model_due();
    int d = 0;
    for (int q = 0; q < NPG; q++)
      if (age[q] > LIM) d = d | (1 << (q >> SPW));
    return d;
  endfunction

  task automatic model_op(input int p);
    for (int q = 0; q < NPG; q++)
      if ((q >> SPW) == (p >> SPW)) begin
        if (q == p) age[q] = 0;
        else if (age[q] <= LIM) age[q] = age[q] + 1;
      end
  endtask

  task automatic check_array();
    int bad = 0, first_act = 0, first_exp = 0;
    @(negedge clk) rd_addr = '0;
    for (int a = 0; a < NARR; a++) begin
      @(negedge clk);
      if (rd_data != 8'((a * 7 + 3) % 256)) begin
        if (bad == 0) begin first_act = rd_data; first_exp = (a * 7 + 3) % 256; end
        bad++;
      end
      rd_addr = 7'(a + 1);
    end
    check("R3/R10 array contents", first_act + 1000 * bad, first_exp);
  endtask

  task automatic rewrite(input int p, input int dc, input int hi);
    int ep0;
    logic [15:0] f;
    f = 16'((hi << 14) | (p << 10) | dc);
    ep0 = episodes;
    send(REWR, f[15:8], f[7:0], 3);
    wait_idle();
    model_op(p);
    check("R1/R2 one operation started", episodes - ep0, 1);
    check("R4 busy length", last_len, XFER + PROG);
    check("R9 refresh_due", int'(refresh_due), model_due());
  endtask

  initial begin
    logic [7:0] sv;
    logic sval;
    int ep0;
    for (int q = 0; q < NPG; q++) age[q] = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11 ready after reset", int'(ready_o), 1);
    check("R11 due after reset", int'(refresh_due), 0);
    check("R11 sdo_valid after reset", int'(sdo_valid), 0);
    stat_read(sv, sval);
    check("R6 status valid idle", int'(sval), 1);
    check("R5 status idle", int'(sv), 8'h80);
    check_array();

    for (int p = 0; p < NPG; p++)
      rewrite(p, (p * 97 + 13) % 1024, p % 4);
    check_array();

    rewrite(1, 1023, 3);
    check("R9 sector0 overdue", int'(refresh_due), 1);
    stat_read(sv, sval);
    check("R5 status with due", int'(sv), 8'h81);
    rewrite(0, 0, 0);
    check("R9 cleared by refresh", int'(refresh_due), 0);

    for (int k = 0; k < 6; k++) rewrite(12, k * 150, k % 4);
    check("R9 saturated sector3", int'(refresh_due), 8);
    rewrite(13, 5, 1);
    rewrite(14, 6, 2);
    rewrite(15, 7, 3);
    check("R9 sector3 cleared", int'(refresh_due), 0);

    ep0 = episodes;
    send(REWR, 8'h08, 8'h00, 2);
    repeat (6) @(negedge clk);
    check("R8 short address ready", int'(ready_o), 1);
    send(REWR, 8'h00, 8'h00, 1);
    send(8'h3C, 8'h08, 8'h00, 3);
    repeat (6) @(negedge clk);
    check("R8 no operation", episodes - ep0, 0);

    ep0 = episodes;
    send(REWR, 8'h08, 8'h00, 3);
    @(negedge clk);
    stat_read(sv, sval);
    check("R6 status valid busy", int'(sval), 1);
    check("R5 status busy", int'(sv), 8'h00);
    send(REWR, 8'h10, 8'h00, 3);
    wait_idle();
    repeat (40) @(negedge clk);
    model_op(2);
    check("R7 ignored while busy", episodes - ep0, 1);
    check("R7 busy length", last_len, XFER + PROG);
    check("R9 after busy test", int'(refresh_due), model_due());
    check_array();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule